// File: doc/BRIEF.md
# Second-Level Page Translation Buffer Controller

This block is the second-level translation buffer that sits behind a small first-level translation buffer. It is consulted only when the first level misses. It returns the page table entry (PTE) for a virtual address when it holds that entry. When it does not, it tells the requester that a refill is needed. A page-table walker outside the block then brings in the missing entry along with its three neighbours as one group.

There are 512 entries in total. The top bit of the virtual address splits them into two halves of 256: the system half (bit 31 = 1) and the process half (bit 31 = 0). Each group of four consecutive entries shares one tag. That gives 128 tags, which live in an on-chip array with a separate valid bit per group. The entries themselves live in a separate synchronous single-port RAM. A process-half flush invalidates every process group in one cycle and leaves the system half untouched.

The page size is 512 bytes, so the virtual page number is va[30:9]. A lookup is pipelined over two cycles. In the first cycle the tag array, the valid bits and the entry RAM are read. In the second cycle the tag is compared and the response is registered.

Top module: `btb_ctrl`

## Requirements
- R1: After reset no response is pending, and every group is invalid, so any lookup misses until a group has been filled.
- R2: A lookup accepted at clock edge k (req_valid high with fill_valid low) produces exactly one response, visible after edge k+1. Lookups may be issued on consecutive cycles, and their responses come out in order on consecutive cycles.
- R3: The entry index is {va[31], va[16:9]}, the group (tag) index is {va[31], va[16:11]}, and the stored tag is va[30:17]. The page offset va[8:0] has no effect on a lookup.
- R4: A lookup whose group is valid and whose tag equals va[30:17] responds with rsp_hit=1 and the PTE written for that entry index.
- R5: Any other lookup responds with rsp_hit=0 and rsp_pte=0, and raises refill_req for that one response cycle only.
- R6: A fill is four beats on consecutive cycles with fill_valid high. Beat n (n = 0..3) writes fill_pte to entry n of the group {fill_va[31], fill_va[16:11]}. The tag comes from fill_va[30:17], and fill_va[10:0] is ignored.
- R7: A group turns invalid at the edge of its first fill beat and becomes valid only at the edge of its fourth beat. A lookup presented in the same cycle as a fill beat is dropped and gets no response.
- R8: If fill_valid drops before four beats, the group stays invalid, and the next fill_valid starts again at beat 0.
- R9: A one-cycle flush_proc pulse invalidates all 64 process-half groups and leaves the system-half groups unchanged. When it coincides with the fourth beat of a process-half group, that group ends up invalid. A system-half group completing in the same cycle becomes valid as usual.
- R10: Two addresses that differ only in bit 31 map to different entries and different tags, and never alias.
- R11: A lookup that hits a valid group whose tag differs from va[30:17] in any bit is a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request from the first-level buffer miss path |
| req_va | input | 32 | Virtual address of the lookup |
| fill_valid | input | 1 | Fill beat present |
| fill_va | input | 32 | Address of the group being filled, held across its beats |
| fill_pte | input | 32 | PTE for the current fill beat |
| flush_proc | input | 1 | Invalidate every process-half group |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Response is a hit |
| rsp_pte | output | 32 | PTE on a hit, zero on a miss |
| refill_req | output | 1 | Response is a miss; a group refill is needed |

## Verification
The bench fills all 128 groups and sweeps all 512 entries with a changing page offset in both halves. A design that dropped bit 31 from an index, or that took index bits from the offset, would return the other half's or a neighbour's PTE. It then flips the top tag bit to catch a design that compares too few tag bits. It also abandons fills after two and after three beats; a design that set the valid bit early would hit on a half-written group. A lookup is raised in the middle of a fill, so a design that served it would produce a stray response. A flush is made to land on the last beat of a process group and, separately, of a system group. A design that ordered flush and fill the wrong way would leave the process group valid, or would wipe out the system half.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int unsigned BTB_VA_W      = 32;
    localparam int unsigned BTB_PG_OFS_W  = 9;
    localparam int unsigned BTB_HALF_IDXW = 8;
    localparam int unsigned BTB_GRP_W     = 2;
    localparam int unsigned BTB_PTE_W     = 32;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_kind_e;

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
    parameter int unsigned VA_W       = 32,
    parameter int unsigned PG_OFS_W   = 9,
    parameter int unsigned HALF_IDX_W = 8,
    parameter int unsigned GRP_W      = 2,
    localparam int unsigned ENT_IDX_W = HALF_IDX_W + 1,
    localparam int unsigned GRP_IDX_W = HALF_IDX_W - GRP_W + 1,
    localparam int unsigned TAG_W     = VA_W - 1 - PG_OFS_W - HALF_IDX_W
) (
    input  logic [VA_W-1:0]      va,
    output logic [ENT_IDX_W-1:0] ent_idx,
    output logic [GRP_IDX_W-1:0] grp_idx,
    output logic [TAG_W-1:0]     tag
);

    logic space_sel;
    logic unused_ofs;

    // Top address bit picks the half and becomes the top index bit.
    assign space_sel  = va[VA_W-1];
    assign ent_idx    = {space_sel, va[PG_OFS_W +: HALF_IDX_W]};
    assign grp_idx    = {space_sel, va[PG_OFS_W+GRP_W +: HALF_IDX_W-GRP_W]};
    assign tag        = va[PG_OFS_W+HALF_IDX_W +: TAG_W];
    assign unused_ofs = ^va[PG_OFS_W-1:0];

endmodule

// File: rtl/btb_tag_store.sv
module btb_tag_store #(
    parameter int unsigned N_GRP     = 128,
    parameter int unsigned TAG_W     = 14,
    localparam int unsigned GRP_IDX_W = $clog2(N_GRP)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [GRP_IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic                 rd_en,
    input  logic [GRP_IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0]     rd_tag_q
);

    logic [TAG_W-1:0] tag_mem [N_GRP];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
        if (rd_en) begin
            rd_tag_q <= tag_mem[rd_idx];
        end
    end

endmodule

// File: rtl/btb_pte_ram.sv
module btb_pte_ram #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned DW    = 32,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata_q
);

    logic [DW-1:0] pte_mem [DEPTH];

    // Single port: a write cycle produces no read data.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                pte_mem[addr] <= wdata;
            end else begin
                rdata_q <= pte_mem[addr];
            end
        end
    end

endmodule

// File: rtl/btb_ctrl.sv
module btb_ctrl
    import btb_pkg::*;
#(
    parameter int unsigned VA_W       = BTB_VA_W,
    parameter int unsigned PG_OFS_W   = BTB_PG_OFS_W,
    parameter int unsigned HALF_IDX_W = BTB_HALF_IDXW,
    parameter int unsigned GRP_W      = BTB_GRP_W,
    parameter int unsigned PTE_W      = BTB_PTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic             fill_valid,
    input  logic [VA_W-1:0]  fill_va,
    input  logic [PTE_W-1:0] fill_pte,
    input  logic             flush_proc,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PTE_W-1:0] rsp_pte,
    output logic             refill_req
);

    localparam int unsigned ENT_IDX_W = HALF_IDX_W + 1;
    localparam int unsigned N_ENT     = 1 << ENT_IDX_W;
    localparam int unsigned GRP_IDX_W = HALF_IDX_W - GRP_W + 1;
    localparam int unsigned N_GRP     = 1 << GRP_IDX_W;
    localparam int unsigned HALF_GRP  = N_GRP / 2;
    localparam int unsigned TAG_W     = VA_W - 1 - PG_OFS_W - HALF_IDX_W;
    localparam logic [GRP_W-1:0] BEAT_LAST = '1;

    typedef struct packed {
        logic [N_GRP-1:0] vld;
        logic [GRP_W-1:0] beat;
        logic             s1_vld;
        logic             s1_grp_vld;
        logic [TAG_W-1:0] s1_tag;
        rsp_kind_e        rsp_kind;
        logic [PTE_W-1:0] rsp_pte;
    } btb_state_t;

    btb_state_t st_d, st_q;

    logic [ENT_IDX_W-1:0] req_ent;
    logic [GRP_IDX_W-1:0] req_grp;
    logic [TAG_W-1:0]     req_tag;
    logic [ENT_IDX_W-1:0] unused_fill_ent;
    logic [GRP_IDX_W-1:0] fill_grp;
    logic [TAG_W-1:0]     fill_tag;

    logic                 lk_accept;
    logic                 tag_wr;
    logic [TAG_W-1:0]     tag_rd_q;
    logic                 ram_en;
    logic [ENT_IDX_W-1:0] ram_addr;
    logic [PTE_W-1:0]     ram_rd_q;
    logic                 s2_hit;
    logic [N_GRP-1:0]     tag_vld_q;

    btb_addr_split #(
        .VA_W(VA_W), .PG_OFS_W(PG_OFS_W), .HALF_IDX_W(HALF_IDX_W), .GRP_W(GRP_W)
    ) u_req_split (
        .va(req_va), .ent_idx(req_ent), .grp_idx(req_grp), .tag(req_tag)
    );

    btb_addr_split #(
        .VA_W(VA_W), .PG_OFS_W(PG_OFS_W), .HALF_IDX_W(HALF_IDX_W), .GRP_W(GRP_W)
    ) u_fill_split (
        .va(fill_va), .ent_idx(unused_fill_ent), .grp_idx(fill_grp), .tag(fill_tag)
    );

    // Fill beats own the RAM port; a lookup in the same cycle is dropped.
    assign lk_accept = req_valid & ~fill_valid;
    assign tag_wr    = fill_valid & (st_q.beat == BEAT_LAST);
    assign ram_en    = fill_valid | lk_accept;
    assign ram_addr  = fill_valid ? {fill_grp, st_q.beat} : req_ent;

    btb_tag_store #(
        .N_GRP(N_GRP), .TAG_W(TAG_W)
    ) u_tags (
        .clk(clk),
        .wr_en(tag_wr), .wr_idx(fill_grp), .wr_tag(fill_tag),
        .rd_en(lk_accept), .rd_idx(req_grp), .rd_tag_q(tag_rd_q)
    );

    btb_pte_ram #(
        .DEPTH(N_ENT), .DW(PTE_W)
    ) u_ptes (
        .clk(clk), .en(ram_en), .we(fill_valid),
        .addr(ram_addr), .wdata(fill_pte), .rdata_q(ram_rd_q)
    );

    assign s2_hit = st_q.s1_vld & st_q.s1_grp_vld & (tag_rd_q == st_q.s1_tag);

    always_comb begin
        st_d = st_q;

        // Stage 1: capture the lookup alongside the array reads.
        st_d.s1_vld     = lk_accept;
        st_d.s1_tag     = req_tag;
        st_d.s1_grp_vld = st_q.vld[req_grp];

        // Stage 2: compare and register the response.
        if (!st_q.s1_vld) begin
            st_d.rsp_kind = RSP_NONE;
            st_d.rsp_pte  = '0;
        end else if (s2_hit) begin
            st_d.rsp_kind = RSP_HIT;
            st_d.rsp_pte  = ram_rd_q;
        end else begin
            st_d.rsp_kind = RSP_MISS;
            st_d.rsp_pte  = '0;
        end

        // Group fill: invalid from first beat, valid after the last.
        if (fill_valid) begin
            if (st_q.beat == '0) begin
                st_d.vld[fill_grp] = 1'b0;
            end
            if (st_q.beat == BEAT_LAST) begin
                st_d.vld[fill_grp] = 1'b1;
            end
            st_d.beat = st_q.beat + GRP_W'(1);
        end else begin
            st_d.beat = '0;
        end

        // Process flush wins over a completing fill in the process half.
        if (flush_proc) begin
            st_d.vld[HALF_GRP-1:0] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld        <= '0;
            st_q.beat       <= '0;
            st_q.s1_vld     <= 1'b0;
            st_q.s1_grp_vld <= 1'b0;
            st_q.s1_tag     <= '0;
            st_q.rsp_kind   <= RSP_NONE;
            st_q.rsp_pte    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = (st_q.rsp_kind != RSP_NONE);
    assign rsp_hit    = (st_q.rsp_kind == RSP_HIT);
    assign refill_req = (st_q.rsp_kind == RSP_MISS);
    assign rsp_pte    = st_q.rsp_pte;
    assign tag_vld_q  = st_q.vld;

endmodule

// File: rtl/btb_ctrl_chk.sv
module btb_ctrl_chk #(
    parameter int unsigned N_GRP = 128,
    parameter int unsigned PTE_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             fill_valid,
    input logic             flush_proc,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [PTE_W-1:0] rsp_pte,
    input logic             refill_req,
    input logic [N_GRP-1:0] tag_vld
);

    localparam int unsigned HALF_GRP = N_GRP / 2;

    logic [1:0] warm_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R2: every response traces back to an accepted lookup two edges earlier
    a_r2_rsp_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2 && rsp_valid) |-> $past(req_valid && !fill_valid, 2));

    // R2 / R7: every accepted lookup is answered
    a_r2_req_gets_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2 && $past(req_valid && !fill_valid, 2)) |-> rsp_valid);

    // R5: refill request only on a missing response
    a_r5_refill_is_miss: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> (rsp_valid && !rsp_hit));

    // R5: a miss carries a zero entry and a refill request
    a_r5_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (refill_req && rsp_pte == '0));

    // R9: flush leaves no process group valid
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd1 && $past(flush_proc)) |-> (tag_vld[HALF_GRP-1:0] == '0));

    // R9: system half changes only through fills
    a_r9_sys_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd1 && !$past(fill_valid))
        |-> (tag_vld[N_GRP-1:HALF_GRP] == $past(tag_vld[N_GRP-1:HALF_GRP])));

    // R7: the valid count grows only after a fill beat
    a_r7_valid_via_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd1 && ($countones(tag_vld) > $past($countones(tag_vld))))
        |-> $past(fill_valid));

endmodule

bind btb_ctrl btb_ctrl_chk #(
    .N_GRP(N_GRP),
    .PTE_W(PTE_W)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .req_valid(req_valid),
    .fill_valid(fill_valid),
    .flush_proc(flush_proc),
    .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit),
    .rsp_pte(rsp_pte),
    .refill_req(refill_req),
    .tag_vld(tag_vld_q)
);

// File: tb/sim_btb_ctrl.sv
`timescale 1ns/1ps
module sim_btb_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_va = '0;
    logic [31:0] fill_pte = '0;
    logic        flush_proc = 1'b0;
    logic        rsp_valid, rsp_hit, refill_req;
    logic [31:0] rsp_pte;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference model of the group state, built from the requirements.
    bit          m_vld [2][64];
    logic [13:0] m_tag [2][64];
    logic [3:0]  m_gen [2][64];

    always #10 clk = ~clk;

    btb_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_va(req_va),
        .fill_valid(fill_valid), .fill_va(fill_va), .fill_pte(fill_pte),
        .flush_proc(flush_proc),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pte(rsp_pte),
        .refill_req(refill_req)
    );

    function automatic logic [31:0] pte_of(input bit h, input logic [13:0] tg,
                                           input logic [7:0] vpn, input logic [3:0] gen);
        return {gen, 1'b0, h, tg, vpn, 4'h9};
    endfunction

    function automatic logic [13:0] tag_for(input int g);
        return 14'((g * 113 + 5) & 16'h3fff);
    endfunction

    function automatic logic [31:0] mk_va(input bit h, input logic [13:0] tg,
                                          input logic [7:0] vpn, input logic [8:0] ofs);
        return {h, tg, vpn, ofs};
    endfunction

    task automatic check(input string r, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", r, what, act, exp);
        end
    endtask

    // One lookup; the response is checked against the model.
    task automatic lookup(input string r, input bit h, input logic [13:0] tg,
                          input logic [7:0] vpn, input logic [8:0] ofs);
        int g = int'(vpn[7:2]);
        bit ehit = m_vld[h][g] && (m_tag[h][g] == tg);
        logic [31:0] epte = ehit ? pte_of(h, tg, vpn, m_gen[h][g]) : 32'h0;
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = mk_va(h, tg, vpn, ofs);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(r, "rsp_valid", {31'h0, rsp_valid}, 32'h1);
        check(r, "rsp_hit", {31'h0, rsp_hit}, {31'h0, ehit});
        check(r, "rsp_pte", rsp_pte, epte);
        check(r, "refill_req", {31'h0, refill_req}, {31'h0, !ehit});
    endtask

    // Fill a group with nbeats beats; optional flush on beat 3 and lookup on beat 1.
    task automatic fill_grp(input bit h, input logic [13:0] tg, input int g,
                            input logic [3:0] gen, input int nbeats,
                            input bit flush_last, input bit req_mid);
        for (int b = 0; b < nbeats; b++) begin
            @(negedge clk);
            if (b == 3 && req_mid) begin
                // R7: the lookup raised at beat 1 must not be answered
                check("R7", "dropped lookup rsp_valid", {31'h0, rsp_valid}, 32'h0);
            end
            fill_valid = 1'b1;
            fill_va    = {h, tg, 6'(g), 2'(b) ^ 2'b10, 9'(g * 5 + b)};
            fill_pte   = pte_of(h, tg, {6'(g), 2'(b)}, gen);
            flush_proc = flush_last && (b == 3);
            req_valid  = req_mid && (b == 1);
            req_va     = mk_va(!h, tag_for(g), {6'(g), 2'b01}, 9'h0);
        end
        @(negedge clk);
        fill_valid = 1'b0;
        flush_proc = 1'b0;
        req_valid  = 1'b0;
        if (nbeats == 4) begin
            m_vld[h][g] = 1'b1;
            m_tag[h][g] = tg;
            m_gen[h][g] = gen;
        end else begin
            m_vld[h][g] = 1'b0;
        end
        if (flush_last && nbeats == 4) begin
            for (int k = 0; k < 64; k++) m_vld[0][k] = 1'b0;
        end
        if (req_mid) begin
            @(negedge clk);
            check("R7", "rsp_valid after fill", {31'h0, rsp_valid}, 32'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int h = 0; h < 2; h++)
            for (int g = 0; g < 64; g++) begin
                m_vld[h][g] = 1'b0; m_tag[h][g] = '0; m_gen[h][g] = '0;
            end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
        check("R1", "refill_req in reset", {31'h0, refill_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
        lookup("R1", 1'b0, 14'h0, 8'h00, 9'h0);
        lookup("R1", 1'b1, tag_for(7), 8'h1d, 9'h1ff);

        // R6 / R10: fill every group in both halves with the same tags
        for (int h = 0; h < 2; h++)
            for (int g = 0; g < 64; g++)
                fill_grp(h[0], tag_for(g), g, 4'(h + 1), 4, 1'b0, 1'b0);

        // R3 / R4 / R10: sweep all 512 entries with a varying offset
        for (int h = 0; h < 2; h++)
            for (int e = 0; e < 256; e++)
                lookup("R4", h[0], tag_for(e / 4), 8'(e), 9'((e * 37 + h * 11) & 9'h1ff));

        // R11 / R5: top tag bit and bottom tag bit flipped
        for (int g = 0; g < 64; g += 3) begin
            lookup("R11", 1'b1, tag_for(g) ^ 14'h2000, {6'(g), 2'b10}, 9'h3);
            lookup("R11", 1'b0, tag_for(g) ^ 14'h0001, {6'(g), 2'b00}, 9'h1);
        end

        // R2: back-to-back lookups answered in order
        @(negedge clk);
        req_valid = 1'b1; req_va = mk_va(1'b1, tag_for(4), 8'h10, 9'h0);
        @(negedge clk);
        req_va = mk_va(1'b0, tag_for(9), 8'h27, 9'h0);
        @(negedge clk);
        check("R2", "b2b rsp0 pte", rsp_pte, pte_of(1'b1, tag_for(4), 8'h10, 4'd2));
        check("R2", "b2b rsp0 valid", {31'h0, rsp_valid}, 32'h1);
        req_va = mk_va(1'b0, tag_for(3) ^ 14'h0100, 8'h0c, 9'h0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", "b2b rsp1 pte", rsp_pte, pte_of(1'b0, tag_for(9), 8'h27, 4'd1));
        check("R2", "b2b rsp1 hit", {31'h0, rsp_hit}, 32'h1);
        @(negedge clk);
        check("R2", "b2b rsp2 miss", {31'h0, refill_req}, 32'h1);
        check("R2", "b2b rsp2 valid", {31'h0, rsp_valid}, 32'h1);
        @(negedge clk);
        check("R2", "no extra rsp", {31'h0, rsp_valid}, 32'h0);

        // R8: abandoned fills after two and three beats leave the group invalid
        fill_grp(1'b1, tag_for(20), 20, 4'd5, 2, 1'b0, 1'b0);
        lookup("R8", 1'b1, tag_for(20), {6'd20, 2'b00}, 9'h0);
        fill_grp(1'b1, tag_for(20), 20, 4'd6, 3, 1'b0, 1'b0);
        lookup("R8", 1'b1, tag_for(20), {6'd20, 2'b10}, 9'h0);
        fill_grp(1'b1, tag_for(20), 20, 4'd7, 4, 1'b0, 1'b0);
        for (int b = 0; b < 4; b++)
            lookup("R8", 1'b1, tag_for(20), {6'd20, 2'(b)}, 9'h0);

        // R7: lookup during a fill is dropped; refill with a new tag
        fill_grp(1'b0, 14'h1abc, 33, 4'd8, 4, 1'b0, 1'b1);
        lookup("R7", 1'b0, 14'h1abc, {6'd33, 2'b11}, 9'h44);
        lookup("R7", 1'b0, tag_for(33), {6'd33, 2'b11}, 9'h44);

        // R9: flush clears process half only
        @(negedge clk);
        flush_proc = 1'b1;
        @(negedge clk);
        flush_proc = 1'b0;
        for (int k = 0; k < 64; k++) m_vld[0][k] = 1'b0;
        for (int g = 0; g < 64; g += 2) begin
            lookup("R9", 1'b0, m_tag[0][g], {6'(g), 2'b01}, 9'h0);
            lookup("R9", 1'b1, m_tag[1][g], {6'(g), 2'b01}, 9'h0);
        end

        // R9: flush coinciding with the last beat
        fill_grp(1'b0, tag_for(5), 5, 4'd9, 4, 1'b0, 1'b0);
        fill_grp(1'b0, tag_for(6), 6, 4'd10, 4, 1'b1, 1'b0);
        lookup("R9", 1'b0, tag_for(6), {6'd6, 2'b00}, 9'h0);
        lookup("R9", 1'b0, tag_for(5), {6'd5, 2'b00}, 9'h0);
        fill_grp(1'b1, 14'h0777, 6, 4'd11, 4, 1'b1, 1'b0);
        lookup("R9", 1'b1, 14'h0777, {6'd6, 2'b10}, 9'h0);
        lookup("R9", 1'b1, tag_for(7), {6'd7, 2'b10}, 9'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule